// File: doc/BRIEF.md
# Link Port Quad-Word Formatter

The formatter builds the payload for one of two independent byte-wide output links. Its inputs are four receive channels and two gain-control paths. Each channel and each path supplies one I/Q sample pair. Each gain-control path also supplies a 12-bit signal-strength value. A three-bit mode input selects which of these sources fill the four 4-byte slots of a 16-byte quad-word. The slots are handed to the link transmitter one word at a time over a valid/ready handshake.

A quad-word starts only when a new sample set is flagged and the transmitter side can take the first word. At that moment every source and the mode are captured, so the four slots of one quad-word always belong to a single moment in time. A parameter fixes whether an instance serves the first or the second link. That choice changes which channels or gain path the instance carries in the split modes.

One mode combination is illegal. When it is seen, a sticky error flag rises and the formatter stops emitting words until reset.

Top module: `lqw_packer`

## Requirements
- R1: After reset, out_valid and cfg_err are both 0.
- R2: Each 32-bit word carries I in bits [31:16] and Q in bits [15:0]. A quad-word is four accepted words, and out_last is 1 only with the fourth.
- R3: When cfg_mode bit0 = 0 and bit1 = 0, the slots carry channels 0, 1, 2, 3 in that order, whatever the value of bit2.
- R4: When cfg_mode bit0 = 0 and bit1 = 1, the first-link instance sends channel 0, 1, 0, 1. The second-link instance sends channel 2, 3, 2, 3.
- R5: When cfg_mode bit0 = 1 and bit2 = 0, the slots alternate gain-path I/Q and signal strength: IQ, RSSI, IQ, RSSI. Gain path A is used when bit1 = 0. When bit1 = 1, the first link uses path A and the second link uses path B.
- R6: An RSSI slot holds the 12-bit value in bits [31:20], zeros in bits [19:16], and zeros in bits [15:0].
- R7: When cfg_mode bit0 = 1, bit1 = 0 and bit2 = 1, all four slots carry gain-path A I/Q words.
- R8: cfg_mode = 3'b111 is invalid. Within one clock it sets cfg_err and drops out_valid, even in the middle of a quad-word. cfg_err stays set until reset, and no word is offered while it is set.
- R9: All four slots of a quad-word come from the inputs present on the clock edge where its first word is loaded. Later input changes do not affect that quad-word.
- R10: While out_valid = 1 and out_ready = 0, out_word and out_valid hold their values.
- R11: With smp_valid and out_ready held at 1, words follow on every cycle with no gap, including across quad-word boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Mode bits: bit0 selects gain-path data, bit1 selects split/dual, bit2 drops RSSI slots |
| smp_valid | input | 1 | A new sample set is present on the source inputs |
| ch_i | input | 64 | Channel I samples, channel k in bits [16k+15:16k] |
| ch_q | input | 64 | Channel Q samples, same packing |
| agc_i | input | 32 | Gain-path I samples, path A low, path B high |
| agc_q | input | 32 | Gain-path Q samples, same packing |
| agc_rssi | input | 24 | Signal strength, path A in [11:0], path B in [23:12] |
| out_valid | output | 1 | out_word holds a word for the transmitter |
| out_ready | input | 1 | Transmitter accepts the word this cycle |
| out_word | output | 32 | Outgoing 4-byte slot |
| out_last | output | 1 | Marks the fourth slot of a quad-word |
| cfg_err | output | 1 | Sticky invalid-configuration flag |

## Verification
The bench builds two instances from the same default widths: 16-bit samples and 12-bit strength values, which leave a 4-bit pad in the RSSI slot. One instance has PORT_B = 0 and the other PORT_B = 1. Both receive identical stimulus, so every split and dual mode is checked for both link assignments in the same cycle. The source inputs are scrambled after each capture and the ready line stalls at random, which brings the snapshot and hold behaviour within reach of the checks.

// File: rtl/lqw_pkg.sv
package lqw_pkg;

  localparam int NUM_CH     = 4;
  localparam int NUM_AGC    = 2;
  localparam int QW_BYTES   = 16;
  localparam int WORD_BYTES = 4;
  localparam int SLOTS      = QW_BYTES / WORD_BYTES;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int IDX_W      = 2;

  // bit0 = use_agc, bit1 = split, bit2 = iq_only
  typedef struct packed {
    logic iq_only;
    logic split;
    logic use_agc;
  } mode_t;

  typedef enum logic [1:0] {
    SRC_CH     = 2'd0,
    SRC_AGC_IQ = 2'd1,
    SRC_RSSI   = 2'd2
  } src_kind_e;

  typedef struct packed {
    src_kind_e        kind;
    logic [IDX_W-1:0] idx;
  } slot_src_t;

  function automatic logic mode_bad(mode_t m);
    return m.use_agc & m.split & m.iq_only;
  endfunction

  function automatic slot_src_t pick_src(mode_t m, logic port_b,
                                         logic [SLOT_W-1:0] slot);
    slot_src_t r;
    r.kind = SRC_CH;
    r.idx  = IDX_W'(slot);
    if (!m.use_agc) begin
      if (m.split) r.idx = {port_b, slot[0]};
    end else begin
      r.idx  = {1'b0, m.split & port_b};
      r.kind = (!m.iq_only && slot[0]) ? SRC_RSSI : SRC_AGC_IQ;
    end
    return r;
  endfunction

endpackage

// File: rtl/lqw_cfg_guard.sv
module lqw_cfg_guard
  import lqw_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode,
  output logic  cfg_bad,
  output logic  cfg_err
);

  assign cfg_bad = mode_bad(mode);

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else if (cfg_bad) cfg_err <= 1'b1;
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  assert_err_follows_mode_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |=> cfg_err);

endmodule

// File: rtl/lqw_snapshot.sv
module lqw_snapshot
  import lqw_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RSSI_W   = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  mode_t                       mode_in,
  input  logic [NUM_CH*SAMPLE_W-1:0]  ch_i_in,
  input  logic [NUM_CH*SAMPLE_W-1:0]  ch_q_in,
  input  logic [NUM_AGC*SAMPLE_W-1:0] agc_i_in,
  input  logic [NUM_AGC*SAMPLE_W-1:0] agc_q_in,
  input  logic [NUM_AGC*RSSI_W-1:0]   rssi_in,
  output mode_t                       mode_q,
  output logic [NUM_CH*SAMPLE_W-1:0]  ch_i_q,
  output logic [NUM_CH*SAMPLE_W-1:0]  ch_q_q,
  output logic [NUM_AGC*SAMPLE_W-1:0] agc_i_q,
  output logic [NUM_AGC*SAMPLE_W-1:0] agc_q_q,
  output logic [NUM_AGC*RSSI_W-1:0]   rssi_q
);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (load) mode_q <= mode_in;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (load) begin
        ch_i_q[c*SAMPLE_W +: SAMPLE_W] <= ch_i_in[c*SAMPLE_W +: SAMPLE_W];
        ch_q_q[c*SAMPLE_W +: SAMPLE_W] <= ch_q_in[c*SAMPLE_W +: SAMPLE_W];
      end
    end
  end

  for (genvar a = 0; a < NUM_AGC; a++) begin : g_agc
    always_ff @(posedge clk) begin
      if (load) begin
        agc_i_q[a*SAMPLE_W +: SAMPLE_W] <= agc_i_in[a*SAMPLE_W +: SAMPLE_W];
        agc_q_q[a*SAMPLE_W +: SAMPLE_W] <= agc_q_in[a*SAMPLE_W +: SAMPLE_W];
        rssi_q[a*RSSI_W +: RSSI_W]      <= rssi_in[a*RSSI_W +: RSSI_W];
      end
    end
  end

endmodule

// File: rtl/lqw_slot_mux.sv
module lqw_slot_mux
  import lqw_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RSSI_W   = 12,
  parameter bit PORT_B   = 1'b0
) (
  input  mode_t                       mode,
  input  logic [SLOT_W-1:0]           slot,
  input  logic [NUM_CH*SAMPLE_W-1:0]  ch_i,
  input  logic [NUM_CH*SAMPLE_W-1:0]  ch_q,
  input  logic [NUM_AGC*SAMPLE_W-1:0] agc_i,
  input  logic [NUM_AGC*SAMPLE_W-1:0] agc_q,
  input  logic [NUM_AGC*RSSI_W-1:0]   rssi,
  output logic [2*SAMPLE_W-1:0]       word
);

  localparam int PAD_W = SAMPLE_W - RSSI_W;

  slot_src_t src;
  int        ch_k;
  int        agc_k;

  always_comb begin
    src   = pick_src(mode, PORT_B, slot);
    ch_k  = int'(src.idx);
    agc_k = int'(src.idx[0]);
    unique case (src.kind)
      SRC_CH:
        word = {ch_i[ch_k*SAMPLE_W +: SAMPLE_W], ch_q[ch_k*SAMPLE_W +: SAMPLE_W]};
      SRC_AGC_IQ:
        word = {agc_i[agc_k*SAMPLE_W +: SAMPLE_W], agc_q[agc_k*SAMPLE_W +: SAMPLE_W]};
      SRC_RSSI:
        word = {rssi[agc_k*RSSI_W +: RSSI_W], {PAD_W{1'b0}}, {SAMPLE_W{1'b0}}};
      default:
        word = '0;
    endcase
  end

endmodule

// File: rtl/lqw_packer.sv
module lqw_packer
  import lqw_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int RSSI_W   = 12,
  parameter bit PORT_B   = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [2:0]                  cfg_mode,
  input  logic                        smp_valid,
  input  logic [NUM_CH*SAMPLE_W-1:0]  ch_i,
  input  logic [NUM_CH*SAMPLE_W-1:0]  ch_q,
  input  logic [NUM_AGC*SAMPLE_W-1:0] agc_i,
  input  logic [NUM_AGC*SAMPLE_W-1:0] agc_q,
  input  logic [NUM_AGC*RSSI_W-1:0]   agc_rssi,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [2*SAMPLE_W-1:0]       out_word,
  output logic                        out_last,
  output logic                        cfg_err
);

  localparam int WORD_W = 2*SAMPLE_W;
  localparam int PAD_W  = SAMPLE_W - RSSI_W;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS-1);

  mode_t live_mode;
  assign live_mode = mode_t'(cfg_mode);

  // configuration guard
  logic cfg_bad;
  lqw_cfg_guard u_guard (
    .clk     (clk),
    .rst     (rst),
    .mode    (live_mode),
    .cfg_bad (cfg_bad),
    .cfg_err (cfg_err)
  );

  logic blocked;
  assign blocked = cfg_bad | cfg_err;

  // sequencing state
  logic              active;
  logic [SLOT_W-1:0] slot;
  logic              adv;
  logic              start;

  assign adv   = !out_valid || out_ready;
  assign start = !active && smp_valid && !blocked && adv;

  // snapshot bank
  mode_t                       snap_mode;
  logic [NUM_CH*SAMPLE_W-1:0]  snap_ch_i, snap_ch_q;
  logic [NUM_AGC*SAMPLE_W-1:0] snap_agc_i, snap_agc_q;
  logic [NUM_AGC*RSSI_W-1:0]   snap_rssi;

  lqw_snapshot #(.SAMPLE_W(SAMPLE_W), .RSSI_W(RSSI_W)) u_snap (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .mode_in  (live_mode),
    .ch_i_in  (ch_i),
    .ch_q_in  (ch_q),
    .agc_i_in (agc_i),
    .agc_q_in (agc_q),
    .rssi_in  (agc_rssi),
    .mode_q   (snap_mode),
    .ch_i_q   (snap_ch_i),
    .ch_q_q   (snap_ch_q),
    .agc_i_q  (snap_agc_i),
    .agc_q_q  (snap_agc_q),
    .rssi_q   (snap_rssi)
  );

  // first slot reads the live inputs, the rest read the snapshot
  mode_t                       mx_mode;
  logic [SLOT_W-1:0]           mx_slot;
  logic [NUM_CH*SAMPLE_W-1:0]  mx_ch_i, mx_ch_q;
  logic [NUM_AGC*SAMPLE_W-1:0] mx_agc_i, mx_agc_q;
  logic [NUM_AGC*RSSI_W-1:0]   mx_rssi;
  logic [WORD_W-1:0]           mx_word;

  always_comb begin
    if (active) begin
      mx_mode  = snap_mode;
      mx_slot  = slot;
      mx_ch_i  = snap_ch_i;
      mx_ch_q  = snap_ch_q;
      mx_agc_i = snap_agc_i;
      mx_agc_q = snap_agc_q;
      mx_rssi  = snap_rssi;
    end else begin
      mx_mode  = live_mode;
      mx_slot  = '0;
      mx_ch_i  = ch_i;
      mx_ch_q  = ch_q;
      mx_agc_i = agc_i;
      mx_agc_q = agc_q;
      mx_rssi  = agc_rssi;
    end
  end

  lqw_slot_mux #(.SAMPLE_W(SAMPLE_W), .RSSI_W(RSSI_W), .PORT_B(PORT_B)) u_mux (
    .mode  (mx_mode),
    .slot  (mx_slot),
    .ch_i  (mx_ch_i),
    .ch_q  (mx_ch_q),
    .agc_i (mx_agc_i),
    .agc_q (mx_agc_q),
    .rssi  (mx_rssi),
    .word  (mx_word)
  );

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_word  <= '0;
      active    <= 1'b0;
      slot      <= '0;
    end else if (blocked) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      active    <= 1'b0;
      slot      <= '0;
    end else if (adv) begin
      if (active) begin
        out_word  <= mx_word;
        out_valid <= 1'b1;
        out_last  <= (slot == LAST_SLOT);
        active    <= (slot != LAST_SLOT);
        slot      <= slot + 1'b1;
      end else if (smp_valid) begin
        out_word  <= mx_word;
        out_valid <= 1'b1;
        out_last  <= 1'b0;
        active    <= 1'b1;
        slot      <= SLOT_W'(1);
      end else begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
    end
  end

  assert_last_with_valid_R2: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  assert_err_silent_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !out_valid);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !blocked) |=> (out_valid && $stable(out_word)));

  assert_no_gap_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_last && !blocked) |=> out_valid);

  assert_rssi_pad_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last && snap_mode.use_agc && !snap_mode.iq_only)
      |-> (out_word[SAMPLE_W+PAD_W-1:0] == '0));

endmodule

// File: tb/lqw_packer_tb_top.sv
module lqw_packer_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic [2:0]  cfg_mode;
  logic        smp_valid;
  logic        out_ready;
  logic [15:0] ci[4], cq[4], ai[2], aq[2];
  logic [11:0] rs[2];
  logic [15:0] s_ci[4], s_cq[4], s_ai[2], s_aq[2];
  logic [11:0] s_rs[2];

  logic [63:0] ch_i_bus, ch_q_bus;
  logic [31:0] agc_i_bus, agc_q_bus;
  logic [23:0] rssi_bus;

  assign ch_i_bus  = {ci[3], ci[2], ci[1], ci[0]};
  assign ch_q_bus  = {cq[3], cq[2], cq[1], cq[0]};
  assign agc_i_bus = {ai[1], ai[0]};
  assign agc_q_bus = {aq[1], aq[0]};
  assign rssi_bus  = {rs[1], rs[0]};

  logic        va, vb, la, lb, ea, eb;
  logic [31:0] wa, wb;

  lqw_packer #(.PORT_B(1'b0)) dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .smp_valid(smp_valid),
    .ch_i(ch_i_bus), .ch_q(ch_q_bus), .agc_i(agc_i_bus), .agc_q(agc_q_bus),
    .agc_rssi(rssi_bus), .out_valid(va), .out_ready(out_ready),
    .out_word(wa), .out_last(la), .cfg_err(ea));

  lqw_packer #(.PORT_B(1'b1)) dut_b_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .smp_valid(smp_valid),
    .ch_i(ch_i_bus), .ch_q(ch_q_bus), .agc_i(agc_i_bus), .agc_q(agc_q_bus),
    .agc_rssi(rssi_bus), .out_valid(vb), .out_ready(out_ready),
    .out_word(wb), .out_last(lb), .cfg_err(eb));

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic randomize_src();
    for (int k = 0; k < 4; k++) begin
      ci[k] = 16'($urandom);
      cq[k] = 16'($urandom);
    end
    for (int k = 0; k < 2; k++) begin
      ai[k] = 16'($urandom);
      aq[k] = 16'($urandom);
      rs[k] = 12'($urandom);
    end
  endtask

  task automatic save_src();
    for (int k = 0; k < 4; k++) begin
      s_ci[k] = ci[k];
      s_cq[k] = cq[k];
    end
    for (int k = 0; k < 2; k++) begin
      s_ai[k] = ai[k];
      s_aq[k] = aq[k];
      s_rs[k] = rs[k];
    end
  endtask

  // Expected slot content from the requirements (R3..R7)
  function automatic logic [31:0] exp_word(logic [2:0] m, bit pb, int s);
    int k;
    if (!m[0]) begin
      k = m[1] ? ((pb ? 2 : 0) + (s % 2)) : s;
      return {s_ci[k], s_cq[k]};
    end
    k = (m[1] && pb) ? 1 : 0;
    if (!m[2] && (s % 2 == 1)) return {s_rs[k], 4'b0000, 16'h0000};
    return {s_ai[k], s_aq[k]};
  endfunction

  function automatic string req_of(logic [2:0] m);
    if (!m[0]) return m[1] ? "R4" : "R3";
    if (!m[2]) return "R5";
    return "R7";
  endfunction

  // One quad-word: capture, scramble inputs (R9), drain with random stalls (R10)
  task automatic run_qw(input logic [2:0] m, input int ready_pct);
    int          got;
    int          guard;
    bit          stalled;
    logic [31:0] held;
    string       rq;
    rq = req_of(m);
    @(negedge clk);
    cfg_mode  = m;
    randomize_src();
    save_src();
    smp_valid = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    chk(va && vb, "R2 quad-word start", {30'd0, va, vb}, 32'd3);
    smp_valid = 1'b0;
    randomize_src();  // R9: later input changes must not reach this quad-word
    got = 0; guard = 0; stalled = 0; held = '0;
    while (got < 4 && guard < 200) begin
      out_ready = (($urandom % 100) < ready_pct);
      #1;
      if (stalled)
        chk(va && wa == held, "R10 hold while stalled", wa, held);
      if (va && out_ready) begin
        chk(wa == exp_word(m, 1'b0, got), {rq, " R9 R6 port A slot"}, wa, exp_word(m, 1'b0, got));
        chk(wb == exp_word(m, 1'b1, got), {rq, " R9 R6 port B slot"}, wb, exp_word(m, 1'b1, got));
        chk(la == (got == 3) && lb == (got == 3), "R2 last flag", {31'd0, la}, {31'd0, got == 3});
        got++;
        stalled = 0;
      end else begin
        stalled = va;
        held    = wa;
      end
      guard++;
      @(negedge clk);
    end
    chk(got == 4, "R2 four words per quad-word", got, 4);
    #1;
    chk(!va && !vb, "R2 idle after quad-word", {31'd0, va}, 0);
  endtask

  initial begin
    rst = 1'b1; cfg_mode = 3'b000; smp_valid = 1'b0; out_ready = 1'b0;
    void'($urandom(32'd1234));
    randomize_src();
    save_src();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!va && !vb, "R1 out_valid after reset", {31'd0, va}, 0);
    chk(!ea && !eb, "R1 cfg_err after reset", {31'd0, ea}, 0);

    // directed modes
    run_qw(3'b000, 100);  // R3
    run_qw(3'b100, 60);   // R3, bit2 ignored
    run_qw(3'b010, 50);   // R4
    run_qw(3'b001, 70);   // R5 path A on both
    run_qw(3'b011, 40);   // R5 dual split
    run_qw(3'b101, 100);  // R7
    run_qw(3'b110, 50);   // R4, bit2 ignored

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [2:0] m;
      m = 3'($urandom);
      if (m == 3'b111) m = 3'b001;
      run_qw(m, 30 + int'($urandom % 71));
    end

    // R11: continuous streaming, constant inputs
    @(negedge clk);
    cfg_mode = 3'b000;
    randomize_src();
    save_src();
    smp_valid = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 12; c++) begin
      chk(va, "R11 no gap", {31'd0, va}, 1);
      chk(wa == exp_word(3'b000, 1'b0, c % 4), "R11 R3 stream word", wa, exp_word(3'b000, 1'b0, c % 4));
      chk(la == (c % 4 == 3), "R11 R2 stream last", {31'd0, la}, {31'd0, c % 4 == 3});
      @(negedge clk);
    end
    smp_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(!va, "R11 drained", {31'd0, va}, 0);

    // R8: invalid mode in the middle of a quad-word
    cfg_mode  = 3'b000;
    smp_valid = 1'b1;
    out_ready = 1'b0;
    @(negedge clk);
    chk(va, "R8 setup quad-word started", {31'd0, va}, 1);
    smp_valid = 1'b0;
    cfg_mode  = 3'b111;
    @(negedge clk);
    chk(ea && eb, "R8 cfg_err set", {31'd0, ea}, 1);
    chk(!va && !vb, "R8 output dropped", {31'd0, va}, 0);
    cfg_mode  = 3'b000;
    smp_valid = 1'b1;
    out_ready = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(ea && eb, "R8 cfg_err sticky", {31'd0, ea}, 1);
      chk(!va && !vb, "R8 no words while error", {31'd0, va}, 0);
    end
    smp_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!ea && !eb, "R8 R1 reset clears cfg_err", {31'd0, ea}, 0);
    run_qw(3'b011, 80);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

endmodule